// File: doc/BRIEF.md
# Offset-Table Address Translator

This block picks, for every memory access beside a virtually indexed cache, how the tag is to be formed. A 2-bit label from the memory instruction selects one of three paths. Private data keeps its virtual page number as the tag, and no translation takes place. A heavily used shared buffer is translated by adding a per-buffer offset to the virtual page number. The offset comes from a small table that system software programs. A rarely used shared buffer is handed to an external data TLB through a request/response handshake.

Because each hot shared buffer is contiguous in both the virtual and the physical space, one offset in page units maps the whole buffer. The cache superset bits are the low bits of the page number that also fall inside the cache index. A separate short adder produces them so that they are ready early for indexing. A wide adder forms the full physical page number.

The table is read in the issue cycle and its result is registered. Offset and bypass results appear in the cycle after issue. TLB results appear in the cycle the TLB responds. The page offset of the address does not pass through this block.

Top module: `xlat_sel_top`

## Requirements
- R1: After reset, out_valid and tlb_req_valid are low and acc_ready is high. Every table entry is invalid, so a label 2'b10 access goes to the TLB until an entry is written.
- R2: An access with label 2'b00 (private) gives out_valid in the cycle after issue. In that result out_ppn equals the virtual page number, out_superset equals its low SS_W bits and out_phys is 0. No TLB request is made.
- R3: An access with label 2'b10 whose selected entry is valid gives out_valid in the cycle after issue. In that result out_ppn = (vpn + offset) mod 2^VPN_W and out_phys is 1.
- R4: On every valid result, out_superset equals the low SS_W bits of out_ppn. The superset bits are the least significant SS_W bits of the page number. On the offset path they come from a separate SS_W-bit adder that wraps modulo 2^SS_W.
- R5: An access with label 2'b01, or with the reserved label 2'b11, raises tlb_req_valid in the cycle after issue, with tlb_req_vpn equal to the page number. Both are held until tlb_resp_valid. The result is valid in the response cycle, with out_ppn equal to tlb_resp_ppn, the superset bits taken from its low bits, and out_phys set to 1.
- R6: A label 2'b10 access whose selected entry is invalid takes the TLB path of R5.
- R7: While a TLB request is waiting for a response, acc_ready is low and any access presented is ignored. No result is ever produced for it.
- R8: A tlb_resp_valid pulse with no request outstanding is ignored and produces no result.
- R9: A configuration write sets the valid bit and offset of one entry. An access issued in a later cycle sees the new contents. An access issued in the same cycle as the write sees the previous contents.
- R10: Bypass and offset accesses may issue in consecutive cycles, and each produces its own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access issue strobe |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_label | input | 2 | Path label from the instruction |
| acc_idx | input | IDX_W | Offset-table index carried with the instruction |
| acc_vpn | input | VPN_W | Virtual page number of the access |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_valid | input | 1 | Valid bit to store |
| cfg_offset | input | VPN_W | Offset in page units to store |
| tlb_req_valid | output | 1 | TLB request outstanding |
| tlb_req_vpn | output | VPN_W | Page number sent to the TLB |
| tlb_resp_valid | input | 1 | TLB response strobe |
| tlb_resp_ppn | input | VPN_W | Physical page number from the TLB |
| out_valid | output | 1 | Result strobe |
| out_ppn | output | VPN_W | Physical (or, for private data, virtual) page number |
| out_superset | output | SS_W | Superset bits for the cache index |
| out_phys | output | 1 | Tag mode: 1 physical, 0 virtual |

## Verification
The bench builds the block with a 20-bit address, 4 KiB pages, 2 superset bits and a 4-entry table. This gives an 8-bit page number, so every virtual page number can be run through every table entry. Offsets of 0, 1, 0x7F and 0xFF make both adders wrap across the sweep. The same small page space lets every private page and a spread of TLB pages be checked against a computed page map, with TLB response delays of zero to three cycles.

// File: rtl/xlat_pkg.sv
// Shared types for the offset-table address translator.
// Assumes the label encoding is fixed by the instruction format.
package xlat_pkg;

    typedef enum logic [1:0] {
        LBL_PRIV = 2'b00,
        LBL_TLB  = 2'b01,
        LBL_OFS  = 2'b10,
        LBL_RSV  = 2'b11
    } label_e;

    typedef enum logic [1:0] {
        PATH_BYP = 2'b00,
        PATH_OFS = 2'b01,
        PATH_TLB = 2'b10
    } path_e;

    // Path choice for a label and the valid bit of the addressed entry.
    function automatic path_e pick_path(input logic [1:0] lbl, input logic ent_valid);
        path_e p;
        case (lbl)
            LBL_PRIV: p = PATH_BYP;
            LBL_OFS:  p = ent_valid ? PATH_OFS : PATH_TLB;
            default:  p = PATH_TLB;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xlat_offset_table.sv
// Programmable table of per-buffer page offsets.
// Reads are combinational from registered storage, so a write is seen
// by reads in later cycles only. Reset clears every entry.
module xlat_offset_table #(
    parameter int DEPTH = 8,
    parameter int OFS_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [OFS_W-1:0] wr_offset,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [OFS_W-1:0] rd_offset
);

    logic [DEPTH-1:0] ent_v;
    logic [OFS_W-1:0] ent_o [DEPTH];
    logic [DEPTH-1:0] wr_hit;

    // One-hot decode of the write index.
    for (genvar e = 0; e < DEPTH; e++) begin : g_dec
        assign wr_hit[e] = wr_en && (wr_idx == IDX_W'(e));
    end

    // Entry storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            for (int e = 0; e < DEPTH; e++) ent_o[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (wr_hit[e]) begin
                    ent_v[e] <= wr_valid;
                    ent_o[e] <= wr_offset;
                end
            end
        end
    end

    // Read port.
    always_comb begin
        rd_valid  = ent_v[rd_idx];
        rd_offset = ent_o[rd_idx];
    end

    p_onehot_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit))
        else $error("table write decode not one-hot");

endmodule

// File: rtl/xlat_offset_adder.sv
// Offset translation: a full-width page adder and a separate short
// superset adder on the low SS_W bits. Both wrap modulo their width.
// Assumes 1 <= SS_W < VPN_W.
module xlat_offset_adder #(
    parameter int VPN_W = 20,
    parameter int SS_W  = 2
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] offset,
    output logic [VPN_W-1:0] ppn,
    output logic [SS_W-1:0]  superset
);

    // Short adder feeding the cache index.
    always_comb superset = vpn[SS_W-1:0] + offset[SS_W-1:0];

    // Wide page adder forming the physical tag.
    always_comb ppn = vpn + offset;

endmodule

// File: rtl/xlat_ctrl.sv
// Issue stage and TLB handshake. Registers the access and its table
// entry at issue, holds a TLB request until the response arrives and
// blocks new accesses meanwhile.
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [1:0]       acc_label,
    input  logic [VPN_W-1:0] acc_vpn,
    input  logic             ent_valid,
    input  logic [VPN_W-1:0] ent_offset,
    input  logic             tlb_resp_valid,
    output logic             acc_ready,
    output logic             s1_valid,
    output path_e            s1_path,
    output logic [VPN_W-1:0] s1_vpn,
    output logic [VPN_W-1:0] s1_offset,
    output logic             s1_done,
    output logic             tlb_req_valid
);

    logic  waiting;
    logic  accept;

    // TLB request outstanding and unanswered.
    always_comb waiting = s1_valid && (s1_path == PATH_TLB) && !tlb_resp_valid;

    // Handshake with the issuing pipeline.
    always_comb begin
        acc_ready     = !waiting;
        accept        = acc_valid && acc_ready;
        s1_done       = s1_valid && !waiting;
        tlb_req_valid = s1_valid && (s1_path == PATH_TLB);
    end

    // Stage register: load on accept, retire on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_path   <= PATH_BYP;
            s1_vpn    <= '0;
            s1_offset <= '0;
        end else if (accept) begin
            s1_valid  <= 1'b1;
            s1_path   <= pick_path(acc_label, ent_valid);
            s1_vpn    <= acc_vpn;
            s1_offset <= ent_offset;
        end else if (s1_done) begin
            s1_valid  <= 1'b0;
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_valid && !tlb_resp_valid) |=> (tlb_req_valid && $stable(s1_vpn)))
        else $error("TLB request dropped before response");

    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_req_valid && !tlb_resp_valid) |-> !acc_ready)
        else $error("access accepted while TLB pending");

endmodule

// File: rtl/xlat_sel_top.sv
// Offset-table address translator top. Selects per access between
// bypass (virtual tag), offset addition and an external TLB, and
// drives the page number, superset bits and tag mode of the result.
module xlat_sel_top
    import xlat_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int SS_W   = 2,
    parameter int DEPTH  = 8,
    localparam int VPN_W = VA_W - PAGE_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    output logic             acc_ready,
    input  logic [1:0]       acc_label,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [VPN_W-1:0] acc_vpn,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_valid,
    input  logic [VPN_W-1:0] cfg_offset,
    output logic             tlb_req_valid,
    output logic [VPN_W-1:0] tlb_req_vpn,
    input  logic             tlb_resp_valid,
    input  logic [VPN_W-1:0] tlb_resp_ppn,
    output logic             out_valid,
    output logic [VPN_W-1:0] out_ppn,
    output logic [SS_W-1:0]  out_superset,
    output logic             out_phys
);

    logic             ent_valid;
    logic [VPN_W-1:0] ent_offset;
    logic             s1_valid;
    path_e            s1_path;
    logic [VPN_W-1:0] s1_vpn;
    logic [VPN_W-1:0] s1_offset;
    logic             s1_done;
    logic [VPN_W-1:0] add_ppn;
    logic [SS_W-1:0]  add_ss;

    xlat_offset_table #(.DEPTH(DEPTH), .OFS_W(VPN_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_valid  (cfg_valid),
        .wr_offset (cfg_offset),
        .rd_idx    (acc_idx),
        .rd_valid  (ent_valid),
        .rd_offset (ent_offset)
    );

    xlat_ctrl #(.VPN_W(VPN_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid      (acc_valid),
        .acc_label      (acc_label),
        .acc_vpn        (acc_vpn),
        .ent_valid      (ent_valid),
        .ent_offset     (ent_offset),
        .tlb_resp_valid (tlb_resp_valid),
        .acc_ready      (acc_ready),
        .s1_valid       (s1_valid),
        .s1_path        (s1_path),
        .s1_vpn         (s1_vpn),
        .s1_offset      (s1_offset),
        .s1_done        (s1_done),
        .tlb_req_valid  (tlb_req_valid)
    );

    xlat_offset_adder #(.VPN_W(VPN_W), .SS_W(SS_W)) u_add (
        .vpn      (s1_vpn),
        .offset   (s1_offset),
        .ppn      (add_ppn),
        .superset (add_ss)
    );

    // Request page number to the TLB.
    always_comb tlb_req_vpn = s1_vpn;

    // Result selection by path.
    always_comb begin
        out_valid    = s1_done;
        out_ppn      = '0;
        out_superset = '0;
        out_phys     = 1'b0;
        if (s1_done) begin
            case (s1_path)
                PATH_BYP: begin
                    out_ppn      = s1_vpn;
                    out_superset = s1_vpn[SS_W-1:0];
                end
                PATH_OFS: begin
                    out_ppn      = add_ppn;
                    out_superset = add_ss;
                    out_phys     = 1'b1;
                end
                default: begin
                    out_ppn      = tlb_resp_ppn;
                    out_superset = tlb_resp_ppn[SS_W-1:0];
                    out_phys     = 1'b1;
                end
            endcase
        end
    end

    p_ss_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_superset == out_ppn[SS_W-1:0]))
        else $error("superset bits disagree with page number");

    p_no_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(acc_valid && acc_ready) || tlb_req_valid))
        else $error("result without an issued access");

    p_virt_no_tlb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_phys) |-> !tlb_req_valid)
        else $error("virtual result while TLB request raised");

endmodule

// File: tb/sim_xlat_sel_top.sv
module sim_xlat_sel_top;

    localparam int VA_W   = 20;
    localparam int PAGE_W = 12;
    localparam int SS_W   = 2;
    localparam int DEPTH  = 4;
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int NPG    = 1 << VPN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic             acc_ready;
    logic [1:0]       acc_label = '0;
    logic [IDX_W-1:0] acc_idx = '0;
    logic [VPN_W-1:0] acc_vpn = '0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic             cfg_valid = 1'b0;
    logic [VPN_W-1:0] cfg_offset = '0;
    logic             tlb_req_valid;
    logic [VPN_W-1:0] tlb_req_vpn;
    logic             tlb_resp_valid = 1'b0;
    logic [VPN_W-1:0] tlb_resp_ppn = '0;
    logic             out_valid;
    logic [VPN_W-1:0] out_ppn;
    logic [SS_W-1:0]  out_superset;
    logic             out_phys;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit          mir_v [DEPTH];
    int          mir_o [DEPTH];

    always #5 clk = ~clk;

    xlat_sel_top #(.VA_W(VA_W), .PAGE_W(PAGE_W), .SS_W(SS_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_label(acc_label), .acc_idx(acc_idx), .acc_vpn(acc_vpn),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_offset(cfg_offset),
        .tlb_req_valid(tlb_req_valid), .tlb_req_vpn(tlb_req_vpn),
        .tlb_resp_valid(tlb_resp_valid), .tlb_resp_ppn(tlb_resp_ppn),
        .out_valid(out_valid), .out_ppn(out_ppn), .out_superset(out_superset),
        .out_phys(out_phys)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Bench page map used as the TLB model.
    function automatic logic [VPN_W-1:0] tlb_map(input int vpn);
        return VPN_W'(vpn * 37 + 11);
    endfunction

    function automatic logic [31:0] pack_out(input logic v, input logic [VPN_W-1:0] p,
                                             input logic [SS_W-1:0] s, input logic ph);
        return 32'({v, p, s, ph});
    endfunction

    task automatic cfg_wr(input int idx, input bit v, input int ofs);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v; cfg_offset = VPN_W'(ofs);
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        mir_v[idx] = v; mir_o[idx] = ofs;
    endtask

    // Issue one access at a negedge and check its result; returns at a negedge.
    task automatic do_acc(input logic [1:0] lbl, input int idx, input int vpn, input int dly,
                          input string rq);
        logic [VPN_W-1:0] e_ppn;
        logic [31:0]      e_pk;
        logic [31:0]      a_pk;
        bit               use_ofs;
        bit               byp;
        acc_valid = 1'b1; acc_label = lbl; acc_idx = IDX_W'(idx); acc_vpn = VPN_W'(vpn);
        use_ofs = (lbl == 2'b10) && mir_v[idx];
        byp = (lbl == 2'b00);
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        if (byp || use_ofs) begin
            e_ppn = byp ? VPN_W'(vpn) : VPN_W'(vpn + mir_o[idx]);
            e_pk  = pack_out(1'b1, e_ppn, e_ppn[SS_W-1:0], !byp);
            a_pk  = pack_out(out_valid, out_ppn, out_superset, out_phys);
            chk(a_pk == e_pk && !tlb_req_valid, rq, a_pk, e_pk);
        end else begin
            for (int k = 0; k <= dly; k++) begin
                if (k > 0) begin @(posedge clk); @(negedge clk); end
                chk(tlb_req_valid && tlb_req_vpn == VPN_W'(vpn) && !out_valid && !acc_ready,
                    {rq, " R5 request"}, 32'({tlb_req_valid, tlb_req_vpn, out_valid}),
                    32'({1'b1, VPN_W'(vpn), 1'b0}));
            end
            e_ppn = tlb_map(vpn);
            tlb_resp_valid = 1'b1; tlb_resp_ppn = e_ppn;
            #1;
            e_pk = pack_out(1'b1, e_ppn, e_ppn[SS_W-1:0], 1'b1);
            a_pk = pack_out(out_valid, out_ppn, out_superset, out_phys);
            chk(a_pk == e_pk, {rq, " R5 response"}, a_pk, e_pk);
            @(posedge clk); @(negedge clk);
            tlb_resp_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < DEPTH; e++) begin mir_v[e] = 0; mir_o[e] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && !tlb_req_valid && acc_ready, "R1 reset",
            32'({out_valid, tlb_req_valid, acc_ready}), 32'b001);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every entry invalid after reset, so offset label goes to TLB
        for (int e = 0; e < DEPTH; e++) do_acc(2'b10, e, 5 + e, 0, "R1 empty table");

        // R3/R4/R10: program offsets that wrap both adders, sweep every page and entry
        cfg_wr(0, 1, 0);
        cfg_wr(1, 1, 1);
        cfg_wr(2, 1, 8'h7F);
        cfg_wr(3, 1, 8'hFF);
        for (int v = 0; v < NPG; v++)
            for (int e = 0; e < DEPTH; e++) do_acc(2'b10, e, v, 0, "R3 R4 R10 offset sweep");

        // R2: private pages, back to back
        for (int v = 0; v < NPG; v++) do_acc(2'b00, v % DEPTH, v, 0, "R2 private sweep");

        // R5: TLB labels with varied response delay
        for (int v = 0; v < NPG; v += 17) begin
            do_acc(2'b01, 0, v, v % 4, "R5 label01");
            do_acc(2'b11, 1, v, (v + 1) % 4, "R5 label11");
        end

        // R6: invalidated entry falls back to TLB
        cfg_wr(2, 0, 8'h40);
        do_acc(2'b10, 2, 8'h33, 1, "R6 invalid entry");
        do_acc(2'b10, 3, 8'h33, 0, "R6 neighbour still valid");

        // R7: access presented while TLB pending is ignored
        acc_valid = 1'b1; acc_label = 2'b01; acc_idx = '0; acc_vpn = 8'h21;
        @(posedge clk); @(negedge clk);
        acc_label = 2'b00; acc_vpn = 8'h99;
        for (int k = 0; k < 2; k++) begin
            chk(!acc_ready && tlb_req_valid && tlb_req_vpn == 8'h21 && !out_valid, "R7 blocked",
                32'({acc_ready, tlb_req_valid, tlb_req_vpn}), 32'({1'b0, 1'b1, 8'h21}));
            @(posedge clk); @(negedge clk);
        end
        acc_valid = 1'b0;
        tlb_resp_valid = 1'b1; tlb_resp_ppn = tlb_map(8'h21);
        #1;
        chk(out_valid && out_ppn == tlb_map(8'h21), "R7 original completes",
            32'(out_ppn), 32'(tlb_map(8'h21)));
        @(posedge clk); @(negedge clk);
        tlb_resp_valid = 1'b0;
        chk(!out_valid && !tlb_req_valid, "R7 ignored access left no result",
            32'({out_valid, tlb_req_valid}), 32'b00);

        // R8: stray response while idle
        tlb_resp_valid = 1'b1; tlb_resp_ppn = 8'h5C;
        #1;
        chk(!out_valid, "R8 stray response same cycle", 32'(out_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        tlb_resp_valid = 1'b0;
        chk(!out_valid && !tlb_req_valid && acc_ready, "R8 stray response after",
            32'({out_valid, tlb_req_valid, acc_ready}), 32'b001);

        // R9: write in the issue cycle is not seen; later access sees it
        cfg_we = 1'b1; cfg_idx = 2'd1; cfg_valid = 1'b1; cfg_offset = 8'h30;
        do_acc(2'b10, 1, 8'h10, 0, "R9 same-cycle old value");
        cfg_we = 1'b0;
        mir_v[1] = 1; mir_o[1] = 8'h30;
        do_acc(2'b10, 1, 8'h10, 0, "R9 new value");
        cfg_wr(2, 1, 8'hE2);
        do_acc(2'b10, 2, 8'h1F, 0, "R9 revalidated entry");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule